// File: doc/BRIEF.md
# Timer Pin Port with Compare Override

This block sits between eight shared pads and a timer. Every pin has a software data bit and a direction bit, both reached over a small register bus. A compare channel can take a pin away from software at any moment by raising its enable for that bit. The pad is then driven from the channel's output value, and software writes still land in the data bit but no longer reach the pad.

Each pad input passes through a two-flop synchronizer. The synchronized levels feed the capture logic on every bit whatever the direction, and one bit is also brought out on its own as the pulse-accumulator input. A read of the data register mixes two sources bit by bit. Bits set as outputs return the stored data bit, and bits set as inputs return the synchronized pad level. The bus has no handshake: a write is accepted on any clock edge where the write strobe is high, and read data follows the address with no wait state.

Top module: `timer_port`

## Requirements
- R1: After reset, the data bits and the direction bits are all zero, every pad output enable is low, and both registers read back as zero while the pads are low.
- R2: A write with `reg_addr`=1 stores `reg_wdata` in the direction bits at that clock edge. A read with `reg_addr`=1 returns the stored direction bits. A direction bit of 1 means output.
- R3: A read with `reg_addr`=0 returns the synchronized pad level for each bit whose direction bit is 0.
- R4: A read with `reg_addr`=0 returns the stored data bit for each bit whose direction bit is 1.
- R5: A write with `reg_addr`=0 updates every data bit, including those of input pins. The value becomes visible once the bit is switched to output.
- R6: When the timer enable of a bit is low, its pad output enable equals its direction bit, and its pad output equals its data bit.
- R7: When the timer enable of a bit is high, the pad output enable is high and the pad output equals the timer value, whatever the direction bit. Data writes do not change that pad.
- R8: `cap_in` carries the synchronized pad level of every bit regardless of direction or timer ownership.
- R9: `pacc_in` equals the synchronized level of bit `PACC_BIT` (default 7). It follows an external signal on that pad while the bit is an input and is not timer-owned.
- R10: A pad change is sampled at the next clock edge and appears on `cap_in` and in data reads after exactly two clock edges, not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects data, 1 selects direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| tmr_oe | input | 8 | Per-bit timer ownership of the pin |
| tmr_val | input | 8 | Per-bit timer output level |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| cap_in | output | 8 | Synchronized pad levels for capture |
| pacc_in | output | 1 | Synchronized pulse-accumulator input |

## Verification
The hardest case to reach is a pin that software has set as an output with known data while a compare channel owns it, followed by a data write. Only the pad shows whether the write leaked through. The stimulus first loads data and direction, then raises the timer enable on two bits with values that differ from the data, and then writes all ones. It checks that the owned bits keep the timer values and that the other bits take the new data. The two-edge synchronizer latency is checked by sampling between the first and second edge after a pad change.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int unsigned PORT_W = 8;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } tport_reg_e;
endpackage

// File: rtl/tport_sync.sv
module tport_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tport_regs.sv
module tport_regs
  import tport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  tport_reg_e   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] port_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      if (addr == REG_DATA) latch_q <= wdata;
      else                  dir_q   <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_view
    assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_comb begin
    rdata = (addr == REG_DIR) ? dir_q : port_view;
  end

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_DIR) |=> dir_q == $past(wdata));
  // R5
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_DATA) |=> latch_q == $past(wdata));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == REG_DATA) |=> $stable(latch_q));
endmodule

// File: rtl/tport_pin_arb.sv
module tport_pin_arb #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] tmr_oe,
  input  logic [W-1:0] tmr_val,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i] = tmr_oe[i] ? tmr_val[i] : latch_q[i];
    assign pad_oe[i]  = tmr_oe[i] | dir_q[i];
  end
endmodule

// File: rtl/timer_port.sv
module timer_port
  import tport_pkg::*;
#(
  parameter int unsigned W           = PORT_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PACC_BIT    = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] tmr_oe,
  input  logic [W-1:0] tmr_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] cap_in,
  output logic         pacc_in
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  tport_reg_e   addr_e;

  assign addr_e = tport_reg_e'(reg_addr);

  tport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  tport_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(addr_e),
    .wdata(reg_wdata), .pin_sync(pin_sync), .rdata(reg_rdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  tport_pin_arb #(.W(W)) u_arb (
    .latch_q(latch_q), .dir_q(dir_q), .tmr_oe(tmr_oe), .tmr_val(tmr_val),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign cap_in  = pin_sync;
  assign pacc_in = pin_sync[PACC_BIT];

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_lat_chk
    // R10
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> cap_in == $past(pad_in, 2));
  end

  // R7
  timer_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & tmr_oe) == tmr_oe) && ((pad_out & tmr_oe) == (tmr_val & tmr_oe)));
  // R6
  sw_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~tmr_oe) == (dir_q & ~tmr_oe));
endmodule

// File: tb/timer_port_tb.sv
`timescale 1ns/1ps
module timer_port_tb;
  localparam int W = 8;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         reg_wr = 0;
  logic         reg_addr = 0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] tmr_oe = '0;
  logic [W-1:0] tmr_val = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, cap_in;
  logic         pacc_in;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  timer_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_oe(tmr_oe),
    .tmr_val(tmr_val), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .cap_in(cap_in), .pacc_in(pacc_in)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [W-1:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic a, output logic [W-1:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_pad(input logic [W-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 pad_oe", pad_oe, 8'h00);
    rd_reg(1'b1, v); check("R1 dir", v, 8'h00);
    rd_reg(1'b0, v); check("R1 data", v, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [W-1:0] v;
    wr_reg(1'b1, 8'hA5);
    rd_reg(1'b1, v); check("R2 dir readback", v, 8'hA5);
    check("R6 oe follows dir", pad_oe, 8'hA5);
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b1, v); check("R2 dir cleared", v, 8'h00);
  endtask

  task automatic t_input_read();
    logic [W-1:0] v;
    set_pad(8'h3C);
    rd_reg(1'b0, v); check("R3 input read", v, 8'h3C);
    check("R8 cap_in input", cap_in, 8'h3C);
  endtask

  task automatic t_latch_hidden();
    logic [W-1:0] v;
    wr_reg(1'b0, 8'h96);
    check("R6 no oe as input", pad_oe, 8'h00);
    rd_reg(1'b0, v); check("R3 still pad level", v, 8'h3C);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b0, v); check("R5 latch revealed", v, 8'h96);
    check("R6 pad_out latch", pad_out, 8'h96);
    check("R6 pad_oe all", pad_oe, 8'hFF);
    check("R8 cap_in as output", cap_in, 8'h3C);
  endtask

  task automatic t_mixed();
    logic [W-1:0] v;
    wr_reg(1'b1, 8'hF0);
    set_pad(8'h0F);
    rd_reg(1'b0, v); check("R4 R3 mixed read", v, 8'h9F);
  endtask

  task automatic t_timer_override();
    logic [W-1:0] v;
    wr_reg(1'b1, 8'h0F);
    @(negedge clk);
    tmr_oe = 8'h81; tmr_val = 8'h01;
    #1;
    check("R7 oe forced", pad_oe, 8'h8F);
    check("R7 pad_out timer", pad_out, 8'h17);
    wr_reg(1'b0, 8'hFF);
    #1;
    check("R7 write blocked on owned bits", pad_out, 8'h7F);
    rd_reg(1'b0, v); check("R4 read latch low nibble", v & 8'h0F, 8'h0F);
    @(negedge clk);
    tmr_oe = 8'h00;
    #1 check("R6 release to latch", pad_out, 8'hFF);
    check("R6 release oe", pad_oe, 8'h0F);
  endtask

  task automatic t_sync_latency();
    wr_reg(1'b1, 8'h00);
    @(negedge clk);
    pad_in = 8'hC3;
    @(negedge clk);
    check("R10 not after one edge", cap_in, 8'h0F);
    @(negedge clk);
    check("R10 after two edges", cap_in, 8'hC3);
  endtask

  task automatic t_pacc();
    set_pad(8'h00);
    check("R9 pacc low", {7'b0, pacc_in}, 8'h00);
    @(negedge clk);
    tmr_oe = 8'h7F; tmr_val = 8'h7F;
    pad_in = 8'h80;
    repeat (2) @(negedge clk);
    check("R9 pacc high", {7'b0, pacc_in}, 8'h01);
    check("R8 cap_in with timer", cap_in, 8'h80);
    @(negedge clk);
    tmr_oe = 8'h00; tmr_val = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dir_rw();
    t_input_read();
    t_latch_hidden();
    t_mixed();
    t_timer_override();
    t_sync_latency();
    t_pacc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule